// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches a running calendar and raises an alarm when the time reaches a programmed value. Two alarms exist, and each has its own compare value for six time fields: second, minute, hour, day of week, day of month and month. Each alarm also has a set of enable bits that choose which of those fields take part in the compare. Fields whose enable is clear are ignored. An alarm can therefore fire once at a single instant, or once per minute, hour or day, and so on.

The calendar counter outside this block supplies the current fields as two-digit BCD bytes. It also supplies a one-cycle strobe each time the time advances by one second. The compare happens only on that strobe, so one matching second produces exactly one event.

Each alarm has two modes. In one-shot mode it disarms itself after it fires. In repeat mode it stays armed, which gives periodic interrupts. A match sets a sticky status flag that the host polls. The host clears a flag by writing a 1 to it. A mask selects which flags drive the shared active-low interrupt line.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset both status flags are 0, `irq_n` is 1, every alarm is disarmed with all field enables clear, and the interrupt mask is 0.
- R2: An armed alarm fires on a strobe when every field whose enable bit is set equals the current field byte. Fields with a clear enable count as matching whatever their value.
- R3: An alarm whose six field enables are all clear never fires, even when armed and in repeat mode.
- R4: The compare is made only in a cycle where `sec_tick` is 1. The flag of a firing alarm reads 1 from the clock edge that samples the strobe. Without a strobe, no flag is set.
- R5: In one-shot mode (repeat bit 0) a firing alarm clears its own arm bit. Later matching strobes then set no flag until the alarm is armed again.
- R6: In repeat mode (repeat bit 1) the alarm stays armed and sets its flag on every matching strobe.
- R7: A status flag stays 1 until a write to the status address with a 1 in that flag's bit position. Writing 0 leaves the flag unchanged. If a clear and a new match occur in the same cycle, the flag stays 1.
- R8: `irq_n` is 0 exactly when some flag is 1 and its mask bit is 1.
- R9: The two alarms are independent. Configuring or firing one never changes the other's flag.
- R10: Register map, written with `cfg_we`, `cfg_addr` and `cfg_wdata`:
  - For addresses 0x00 to 0x0F, `cfg_addr[3]` selects the alarm.
  - `cfg_addr[2:0]` values 0 to 5 hold the compare bytes for second, minute, hour, day of week, date and month.
  - `cfg_addr[2:0]` value 6 is the control byte. Bits [5:0] are the field enables, in the same field order. Bit 6 is repeat and bit 7 is arm.
  - Address 0x10 is status, write-1-to-clear, with bit n for alarm n.
  - Address 0x11 is the interrupt mask, with bit n for alarm n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe at each seconds update |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_dow | input | 8 | Current day of week |
| cur_date | input | 8 | Current day of month, BCD |
| cur_month | input | 8 | Current month, BCD |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| alm_flag | output | 2 | Sticky alarm status flags |
| irq_n | output | 1 | Active-low combined interrupt request |

## Verification
A wrong arm bit or a wrong enable bit inside the block shows up on the first matching strobe. A flag is then missing or extra on `alm_flag` one clock later, and `irq_n` is wrong at the same moment whenever the mask bit is set. A one-shot alarm that fails to disarm only shows on a second matching strobe, so the bench fires each one-shot alarm twice. A status register that loses or wrongly keeps a bit shows on the cycle right after a clear write. A clear and a match in the same cycle exposes a wrong priority between the two.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int FIELD_W    = 8;
  localparam int ADDR_W     = 5;
  localparam int OFS_W      = 3;

  typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] tvec_t;

  localparam logic [OFS_W-1:0]  CTRL_OFS  = 3'd6;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 5'h10;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 5'h11;
  localparam int REP_BIT = 6;
  localparam int ARM_BIT = 7;
endpackage

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
  import cal_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [OFS_W-1:0]      wr_ofs,
  input  logic [FIELD_W-1:0]    wr_data,
  input  logic                  fired,
  output tvec_t                 vals,
  output logic [NUM_FIELDS-1:0] en,
  output logic                  rep,
  output logic                  arm
);
  tvec_t                 vals_d, vals_q;
  logic [NUM_FIELDS-1:0] en_d, en_q;
  logic                  rep_d, rep_q, arm_d, arm_q;

  always_comb begin
    vals_d = vals_q;
    en_d   = en_q;
    rep_d  = rep_q;
    arm_d  = arm_q;
    if (fired && !rep_q) arm_d = 1'b0;
    if (wr_en) begin
      if (wr_ofs == CTRL_OFS) begin
        en_d  = wr_data[NUM_FIELDS-1:0];
        rep_d = wr_data[REP_BIT];
        arm_d = wr_data[ARM_BIT];
      end else if (int'(wr_ofs) < NUM_FIELDS) begin
        vals_d[wr_ofs] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vals_q <= '0;
      en_q   <= '0;
      rep_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      vals_q <= vals_d;
      en_q   <= en_d;
      rep_q  <= rep_d;
      arm_q  <= arm_d;
    end
  end

  assign vals = vals_q;
  assign en   = en_q;
  assign rep  = rep_q;
  assign arm  = arm_q;
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import cal_alarm_pkg::*;
(
  input  logic                  tick,
  input  logic                  arm,
  input  logic [NUM_FIELDS-1:0] en,
  input  tvec_t                 vals,
  input  tvec_t                 cur,
  output logic                  hit
);
  logic [NUM_FIELDS-1:0] fld_ok;

  generate
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      assign fld_ok[f] = !en[f] || (vals[f] == cur[f]);
    end
  endgenerate

  assign hit = tick && arm && (|en) && (&fld_ok);
endmodule

// File: rtl/alarm_status.sv
module alarm_status #(
  parameter int N_ALM = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ALM-1:0] hit,
  input  logic             clr_we,
  input  logic             mask_we,
  input  logic [N_ALM-1:0] wbits,
  output logic [N_ALM-1:0] flag,
  output logic             irq_n
);
  logic [N_ALM-1:0] flag_d, flag_q, mask_d, mask_q;

  always_comb begin
    flag_d = flag_q;
    if (clr_we) flag_d = flag_d & ~wbits;
    flag_d = flag_d | hit;
    mask_d = mask_we ? wbits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  assign flag  = flag_q;
  assign irq_n = ~|(flag_q & mask_q);
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
#(
  parameter int N_ALM = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [FIELD_W-1:0] cur_dow,
  input  logic [FIELD_W-1:0] cur_date,
  input  logic [FIELD_W-1:0] cur_month,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [FIELD_W-1:0] cfg_wdata,
  output logic [N_ALM-1:0]   alm_flag,
  output logic               irq_n
);
  tvec_t            cur;
  logic [N_ALM-1:0] hit;

  assign cur = {cur_month, cur_date, cur_dow, cur_hour, cur_min, cur_sec};

  generate
    for (genvar a = 0; a < N_ALM; a++) begin : g_alm
      tvec_t                 vals;
      logic [NUM_FIELDS-1:0] en;
      logic                  rep, arm, sel;

      assign sel = cfg_we && !cfg_addr[ADDR_W-1] && (cfg_addr[OFS_W] == a[0]);

      alarm_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(sel), .wr_ofs(cfg_addr[OFS_W-1:0]),
        .wr_data(cfg_wdata), .fired(hit[a]), .vals(vals), .en(en),
        .rep(rep), .arm(arm)
      );

      alarm_compare u_cmp (
        .tick(sec_tick), .arm(arm), .en(en), .vals(vals), .cur(cur),
        .hit(hit[a])
      );
    end
  endgenerate

  alarm_status #(.N_ALM(N_ALM)) u_stat (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .clr_we(cfg_we && cfg_addr == STAT_ADDR),
    .mask_we(cfg_we && cfg_addr == MASK_ADDR),
    .wbits(cfg_wdata[N_ALM-1:0]), .flag(alm_flag), .irq_n(irq_n)
  );
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
  import cal_alarm_pkg::*;
#(
  parameter int N_ALM = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sec_tick,
  input logic               cfg_we,
  input logic [ADDR_W-1:0]  cfg_addr,
  input logic [FIELD_W-1:0] cfg_wdata,
  input logic [N_ALM-1:0]   alm_flag,
  input logic               irq_n
);
  logic stat_wr;
  assign stat_wr = cfg_we && (cfg_addr == STAT_ADDR);

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|alm_flag)); // R8

  generate
    for (genvar a = 0; a < N_ALM; a++) begin : g_chk
      AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flag[a]) |-> $past(sec_tick)); // R4

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_flag[a] && !(stat_wr && cfg_wdata[a])) |=> alm_flag[a]); // R7

      AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && cfg_wdata[a] && !sec_tick) |=> !alm_flag[a]); // R7

      AST_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !alm_flag[a]) |=> !alm_flag[a]); // R4
    end
  endgenerate
endmodule

bind cal_alarm_unit cal_alarm_chk #(.N_ALM(N_ALM)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .alm_flag(alm_flag),
  .irq_n(irq_n)
);

// File: tb/sim_cal_alarm_unit.sv
`timescale 1ns/1ps
module sim_cal_alarm_unit;
  logic       clk = 1'b0;
  logic       rst_n, sec_tick, cfg_we;
  logic [7:0] cur_sec, cur_min, cur_hour, cur_dow, cur_date, cur_month;
  logic [4:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [1:0] alm_flag;
  logic       irq_n;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cal_alarm_unit u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_dow(cur_dow),
    .cur_date(cur_date), .cur_month(cur_month), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .alm_flag(alm_flag),
    .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo);
    @(negedge clk);
    cur_sec = s; cur_min = mi; cur_hour = h;
    cur_dow = dw; cur_date = dt; cur_month = mo;
  endtask

  task automatic t_reset();
    chk("R1 flags", {6'd0, alm_flag}, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    tick();
    chk("R1 disarmed after reset", {6'd0, alm_flag}, 8'h00);
  endtask

  task automatic t_oneshot();
    wr(5'h01, 8'h15); wr(5'h02, 8'h08); wr(5'h06, 8'h86);
    set_time(8'h42, 8'h15, 8'h08, 8'h03, 8'h21, 8'h06);
    tick();
    chk("R2 R10 min+hour match", {6'd0, alm_flag}, 8'h01);
    chk("R8 masked irq_n", {7'd0, irq_n}, 8'h01);
    wr(5'h11, 8'h01);
    chk("R8 unmasked irq_n", {7'd0, irq_n}, 8'h00);
    wr(5'h10, 8'h00);
    chk("R7 write 0 keeps flag", {6'd0, alm_flag}, 8'h01);
    wr(5'h10, 8'h01);
    chk("R7 write 1 clears", {6'd0, alm_flag}, 8'h00);
    chk("R8 irq_n released", {7'd0, irq_n}, 8'h01);
    tick();
    chk("R5 one-shot disarmed", {6'd0, alm_flag}, 8'h00);
  endtask

  task automatic t_fields();
    wr(5'h06, 8'h86);
    set_time(8'h42, 8'h15, 8'h09, 8'h03, 8'h21, 8'h06);
    tick();
    chk("R2 enabled hour mismatch", {6'd0, alm_flag}, 8'h00);
    wr(5'h00, 8'h42); wr(5'h03, 8'h03); wr(5'h04, 8'h21); wr(5'h05, 8'h06);
    wr(5'h06, 8'hBF);
    set_time(8'h42, 8'h15, 8'h08, 8'h04, 8'h21, 8'h06);
    tick();
    chk("R2 day-of-week mismatch", {6'd0, alm_flag}, 8'h00);
    set_time(8'h42, 8'h15, 8'h08, 8'h03, 8'h21, 8'h06);
    tick();
    chk("R2 all six fields match", {6'd0, alm_flag}, 8'h01);
    wr(5'h10, 8'h01);
  endtask

  task automatic t_no_enable();
    wr(5'h06, 8'hC0);
    tick();
    chk("R3 no field enabled", {6'd0, alm_flag}, 8'h00);
  endtask

  task automatic t_repeat();
    wr(5'h08, 8'h30); wr(5'h0E, 8'hC1); wr(5'h11, 8'h03);
    set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01);
    tick();
    chk("R6 R9 alarm 1 fires alone", {6'd0, alm_flag}, 8'h02);
    chk("R8 irq_n from alarm 1", {7'd0, irq_n}, 8'h00);
    wr(5'h10, 8'h02);
    set_time(8'h31, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01);
    tick();
    chk("R6 no match at 31", {6'd0, alm_flag}, 8'h00);
    set_time(8'h30, 8'h01, 8'h00, 8'h01, 8'h01, 8'h01);
    tick();
    chk("R6 repeat re-fires", {6'd0, alm_flag}, 8'h02);
  endtask

  task automatic t_priority();
    @(negedge clk);
    sec_tick = 1'b1; cfg_we = 1'b1; cfg_addr = 5'h10; cfg_wdata = 8'h02;
    @(negedge clk);
    sec_tick = 1'b0; cfg_we = 1'b0;
    chk("R7 set wins over clear", {6'd0, alm_flag}, 8'h02);
    wr(5'h10, 8'h02);
    repeat (5) @(negedge clk);
    chk("R4 match without strobe", {6'd0, alm_flag}, 8'h00);
    tick();
    chk("R4 strobe fires", {6'd0, alm_flag}, 8'h02);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    cur_sec = '0; cur_min = '0; cur_hour = '0; cur_dow = '0; cur_date = '0; cur_month = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_fields();
    t_no_enable();
    t_repeat();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule